// File: doc/BRIEF.md
# APB Watchdog Timer

This block is a down-counting watchdog that sits on an APB slave port. Software programs a reload value and sets the interrupt-enable control bit. From then on the counter loses one per clock. When it reaches zero it raises an interrupt and starts again from the reload value. If software has not cleared that interrupt by the next time the count reaches zero, and reset-enable is set, the block issues a one-cycle reset request to the system. Clearing the interrupt also restarts the count, which is how software keeps the watchdog quiet.

The counter runs only while interrupt-enable is set. Setting it restarts the count from the reload value, and clearing it freezes the count where it is. A lock register guards every other register against stray writes. A build parameter selects a variant whose control register cannot be changed, after interrupt-enable has been set, until the next reset.

Register word index is `paddr[4:2]`. An access hits only when `paddr[1:0]` is zero and every address bit from 5 upward is zero. Any other address reads zero and ignores writes.

Top module: `apb_wdog`

## Requirements
- R1: After synchronous reset the reload value and the count are both 0xFFFFFFFF, the counter is stopped, the interrupt status, reset status and lock are all 0, and `irq` and `rst_req` are low.
- R2: A write to index 0 (reload) sets the reload value and the count to the written word, and it does not change whether the counter is running. Index 0 reads back the reload value.
- R3: While interrupt-enable is 1 and no write touches the count, a nonzero count decreases by exactly one per clock. A change of interrupt-enable from 0 to 1 loads the count from the reload value. Index 1 reads the live count.
- R4: A change of interrupt-enable from 1 to 0 freezes the count. A control write that leaves interrupt-enable unchanged does not disturb the count.
- R5: The control register at index 2 stores only bit 0 (interrupt-enable) and bit 1 (reset-enable). All other written bits are discarded and read back as 0.
- R6: When the running count is 0 at a clock edge, the count reloads from the reload value and the raw interrupt status (index 4, bit 0) becomes 1.
- R7: If the raw interrupt status is already 1 at such a zero and reset-enable is 1, `rst_req` is high for the following cycle and the sticky reset status (index 6, bit 0) becomes 1. With reset-enable at 0, no request is made.
- R8: A write of any value to index 3 (clear) clears the raw interrupt status and reloads the count from the reload value. Index 3 reads as 0.
- R9: `irq` and the masked status (index 5, bit 0) both equal the raw interrupt status ANDed with interrupt-enable.
- R10: A write to index 7 (lock) locks the block unless the word is 0x1ACCE551, which unlocks it. While locked, writes to every other index are ignored. Index 7 reads 1 when locked and 0 when not.
- R11: With `STICKY_CTRL`=1, once interrupt-enable is 1, writes to the control register are ignored until reset. With `STICKY_CTRL`=0, the control register is always writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data (combinational from `paddr`) |
| irq | output | 1 | Watchdog interrupt, active high |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The counter is tried with a long reload that lets it wrap several times. It is also tried with a reload of zero, which makes it expire on every cycle, and with a reload written while the counter is stopped and then started. Together these show whether the count reloads from the right source and whether expiry lands in the right cycle.

Control writes are made that toggle interrupt-enable, and others that leave it unchanged while flipping reset-enable or undefined bits. These separate a true freeze from a restart and from a disturbance that should not happen. Writes are also made while the block is locked, to unmapped addresses, and to the sticky variant after it has been enabled. Each must leave the state untouched, and this is seen through the read port, against a cycle-accurate model running side by side.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

    typedef enum logic [2:0] {
        RI_LOAD    = 3'd0,
        RI_COUNT   = 3'd1,
        RI_CTRL    = 3'd2,
        RI_CLEAR   = 3'd3,
        RI_RAW     = 3'd4,
        RI_MASKED  = 3'd5,
        RI_RSTSTAT = 3'd6,
        RI_LOCK    = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic rst_en;
        logic int_en;
    } ctrl_t;

    typedef struct packed {
        logic load;
        logic ctrl;
        logic clear;
        logic lock;
    } wr_strobe_t;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_CLEAR,
        ACT_START,
        ACT_STOP,
        ACT_EXPIRE,
        ACT_TICK
    } cnt_act_e;

    function automatic ctrl_t ctrl_from_bits(logic [1:0] b);
        ctrl_t c;
        c.int_en = b[0];
        c.rst_en = b[1];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_to_word(ctrl_t c);
        return {30'b0, c.rst_en, c.int_en};
    endfunction

endpackage

// File: rtl/wdog_apb_if.sv
module wdog_apb_if
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    input  logic [31:0]       rd_load,
    input  logic [31:0]       rd_count,
    input  ctrl_t             rd_ctrl,
    input  logic              rd_raw,
    input  logic              rd_masked,
    input  logic              rd_rststat,
    output logic [31:0]       prdata,
    output wr_strobe_t        wr,
    output logic              locked
);
    localparam int HI_W = ADDR_W - 5;

    logic     hit;
    logic     access;
    reg_idx_e idx;

    assign hit    = (paddr[ADDR_W-1:5] == HI_W'(0)) && (paddr[1:0] == 2'b00);
    assign access = psel && penable && pwrite && hit;
    assign idx    = reg_idx_e'(paddr[4:2]);

    always_comb begin
        wr       = '0;
        wr.lock  = access && (idx == RI_LOCK);
        wr.load  = access && !locked && (idx == RI_LOAD);
        wr.ctrl  = access && !locked && (idx == RI_CTRL);
        wr.clear = access && !locked && (idx == RI_CLEAR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
        end else if (wr.lock) begin
            locked <= (pwdata != UNLOCK_KEY);
        end
    end

    always_comb begin
        prdata = '0;
        if (hit) begin
            case (idx)
                RI_LOAD:    prdata = rd_load;
                RI_COUNT:   prdata = rd_count;
                RI_CTRL:    prdata = ctrl_to_word(rd_ctrl);
                RI_RAW:     prdata = {31'b0, rd_raw};
                RI_MASKED:  prdata = {31'b0, rd_masked};
                RI_RSTSTAT: prdata = {31'b0, rd_rststat};
                RI_LOCK:    prdata = {31'b0, locked};
                default:    prdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter bit STICKY_CTRL = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ctrl,
    input  logic [1:0] wbits,
    output ctrl_t      ctrl_q,
    output logic       en_rise,
    output logic       en_fall
);
    ctrl_t nxt;
    logic  accept;

    assign nxt = ctrl_from_bits(wbits);

    generate
        if (STICKY_CTRL) begin : g_sticky
            assign accept = wr_ctrl && !ctrl_q.int_en;
        end else begin : g_plain
            assign accept = wr_ctrl;
        end
    endgenerate

    assign en_rise = accept && nxt.int_en && !ctrl_q.int_en;
    assign en_fall = accept && !nxt.int_en && ctrl_q.int_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (accept) begin
            ctrl_q <= nxt;
        end
    end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_load,
    input  logic             wr_clear,
    input  logic             en_rise,
    input  logic             en_fall,
    input  logic [CNT_W-1:0] wval,
    input  logic             running,
    input  logic             rst_en,
    output logic [CNT_W-1:0] load_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             int_stat,
    output logic             rst_stat,
    output logic             rst_req
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;
    localparam logic [CNT_W-1:0] ZERO     = '0;

    cnt_act_e act;

    always_comb begin
        if (wr_load)              act = ACT_LOAD;
        else if (wr_clear)        act = ACT_CLEAR;
        else if (en_rise)         act = ACT_START;
        else if (en_fall)         act = ACT_STOP;
        else if (!running)        act = ACT_HOLD;
        else if (cnt_q == ZERO)   act = ACT_EXPIRE;
        else                      act = ACT_TICK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q   <= ALL_ONES;
            cnt_q    <= ALL_ONES;
            int_stat <= 1'b0;
            rst_stat <= 1'b0;
            rst_req  <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            case (act)
                ACT_LOAD: begin
                    load_q <= wval;
                    cnt_q  <= wval;
                end
                ACT_CLEAR: begin
                    int_stat <= 1'b0;
                    cnt_q    <= load_q;
                end
                ACT_START: cnt_q <= load_q;
                ACT_EXPIRE: begin
                    cnt_q    <= load_q;
                    int_stat <= 1'b1;
                    if (int_stat && rst_en) begin
                        rst_req  <= 1'b1;
                        rst_stat <= 1'b1;
                    end
                end
                ACT_TICK: cnt_q <= cnt_q - 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/apb_wdog.sv
module apb_wdog
    import wdog_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int CNT_W       = 32,
    parameter bit STICKY_CTRL = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              irq,
    output logic              rst_req
);
    wr_strobe_t       wr;
    logic             locked;
    ctrl_t            ctrl_q;
    logic             en_rise;
    logic             en_fall;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cnt_q;
    logic             int_stat;
    logic             rst_stat;
    logic             int_en;
    logic             cnt_touch;

    assign int_en    = ctrl_q.int_en;
    assign irq       = int_stat && int_en;
    assign cnt_touch = wr.load || wr.clear || en_rise || en_fall;

    wdog_apb_if #(.ADDR_W(ADDR_W)) u_if (
        .clk        (clk),
        .rst        (rst),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .rd_load    (32'(load_q)),
        .rd_count   (32'(cnt_q)),
        .rd_ctrl    (ctrl_q),
        .rd_raw     (int_stat),
        .rd_masked  (irq),
        .rd_rststat (rst_stat),
        .prdata     (prdata),
        .wr         (wr),
        .locked     (locked)
    );

    wdog_ctrl #(.STICKY_CTRL(STICKY_CTRL)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr.ctrl),
        .wbits   (pwdata[1:0]),
        .ctrl_q  (ctrl_q),
        .en_rise (en_rise),
        .en_fall (en_fall)
    );

    wdog_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .wr_load  (wr.load),
        .wr_clear (wr.clear),
        .en_rise  (en_rise),
        .en_fall  (en_fall),
        .wval     (CNT_W'(pwdata)),
        .running  (int_en),
        .rst_en   (ctrl_q.rst_en),
        .load_q   (load_q),
        .cnt_q    (cnt_q),
        .int_stat (int_stat),
        .rst_stat (rst_stat),
        .rst_req  (rst_req)
    );

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int CNT_W  = 32,
    parameter bit STICKY = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             rst_req,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] load_q,
    input logic             int_stat,
    input logic             rst_stat,
    input logic             int_en,
    input logic             cnt_touch
);
    // R1
    rst_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt_q == '1 && load_q == '1 && !int_stat && !rst_req && !int_en));

    // R3
    tick_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && int_en && !cnt_touch && cnt_q != '0) |-> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !int_en && !cnt_touch) |-> $stable(cnt_q));

    // R6
    expire_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && int_en && !cnt_touch && cnt_q == '0) |-> (int_stat && cnt_q == $past(load_q)));

    // R7
    rst_req_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (int_stat && rst_stat));

    generate
        if (STICKY) begin : g_sticky_chk
            // R11
            sticky_en_chk: assert property (@(posedge clk) disable iff (rst)
                $past(!rst && int_en) |-> int_en);
        end
    endgenerate

endmodule

bind apb_wdog wdog_chk #(.CNT_W(CNT_W), .STICKY(STICKY_CTRL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rst_req   (rst_req),
    .cnt_q     (cnt_q),
    .load_q    (load_q),
    .int_stat  (int_stat),
    .rst_stat  (rst_stat),
    .int_en    (int_en),
    .cnt_touch (cnt_touch)
);

// File: tb/sim_apb_wdog.sv
`timescale 1ns/1ps
module sim_apb_wdog;
    localparam logic [31:0] KEY = 32'h1ACC_E551;
    localparam logic [11:0] A_LOAD = 12'h000, A_COUNT = 12'h004, A_CTRL = 12'h008,
                            A_CLEAR = 12'h00C, A_RAW = 12'h010, A_RSTST = 12'h018,
                            A_LOCK = 12'h01C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata0, prdata1;
    logic        irq0, irq1, rr0, rr1;

    always #2 clk = ~clk;

    apb_wdog #(.ADDR_W(12), .CNT_W(32), .STICKY_CTRL(1'b0)) u0 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata0), .irq(irq0), .rst_req(rr0));

    apb_wdog #(.ADDR_W(12), .CNT_W(32), .STICKY_CTRL(1'b1)) u1 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata1), .irq(irq1), .rst_req(rr1));

    integer checks = 0;
    integer failures = 0;
    integer pulses0 = 0;
    bit     done = 0;

    // behavioural reference state, index 0 = plain variant, 1 = sticky variant
    logic [31:0] m_load [2];
    logic [31:0] m_cnt  [2];
    bit m_en [2], m_res [2], m_int [2], m_rst [2], m_lock [2], m_req [2];

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input int v, input logic [11:0] a);
        if (a[11:5] != 0 || a[1:0] != 0) return 32'h0;
        case (a[4:2])
            3'd0: return m_load[v];
            3'd1: return m_cnt[v];
            3'd2: return {30'b0, m_res[v], m_en[v]};
            3'd4: return {31'b0, m_int[v]};
            3'd5: return {31'b0, m_int[v] & m_en[v]};
            3'd6: return {31'b0, m_rst[v]};
            3'd7: return {31'b0, m_lock[v]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input int v, input logic [11:0] a);
        if (v == 1 && a[4:2] == 3'd2) return "R11 ctrl";
        case (a[4:2])
            3'd0: return "R2 reload";
            3'd1: return "R3 count";
            3'd2: return "R5 ctrl";
            3'd3: return "R8 clear";
            3'd4: return "R6 raw";
            3'd5: return "R9 masked";
            3'd6: return "R7 rststat";
            default: return "R10 lock";
        endcase
    endfunction

    always @(posedge clk) begin
        for (int v = 0; v < 2; v++) begin
            bit acc, touched, old_en, old_res;
            if (rst) begin
                m_load[v] = 32'hFFFF_FFFF; m_cnt[v] = 32'hFFFF_FFFF;
                m_en[v] = 0; m_res[v] = 0; m_int[v] = 0; m_rst[v] = 0;
                m_lock[v] = 0; m_req[v] = 0;
            end else begin
                acc = psel && penable && pwrite && paddr[11:5] == 0 && paddr[1:0] == 0;
                old_en = m_en[v]; old_res = m_res[v]; touched = 0; m_req[v] = 0;
                if (acc) begin
                    case (paddr[4:2])
                        3'd7: m_lock[v] = (pwdata != KEY);
                        3'd0: if (!m_lock[v]) begin
                            m_load[v] = pwdata; m_cnt[v] = pwdata; touched = 1;
                        end
                        3'd2: if (!m_lock[v] && !(v == 1 && old_en)) begin
                            m_res[v] = pwdata[1];
                            if (pwdata[0] != old_en) begin
                                touched = 1;
                                m_en[v] = pwdata[0];
                                if (pwdata[0]) m_cnt[v] = m_load[v];
                            end
                        end
                        3'd3: if (!m_lock[v]) begin
                            m_int[v] = 0; m_cnt[v] = m_load[v]; touched = 1;
                        end
                        default: ;
                    endcase
                end
                if (!touched && old_en) begin
                    if (m_cnt[v] == 0) begin
                        if (m_int[v] && old_res) begin m_req[v] = 1; m_rst[v] = 1; end
                        m_int[v] = 1;
                        m_cnt[v] = m_load[v];
                    end else begin
                        m_cnt[v] = m_cnt[v] - 1;
                    end
                end
            end
        end
    end

    // cycle-by-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check32("R9 irq u0", {31'b0, irq0}, {31'b0, m_int[0] & m_en[0]});
            check32("R9 irq u1", {31'b0, irq1}, {31'b0, m_int[1] & m_en[1]});
            check32("R7 rst_req u0", {31'b0, rr0}, {31'b0, m_req[0]});
            check32("R7 rst_req u1", {31'b0, rr1}, {31'b0, m_req[1]});
            check32(tag_of(0, paddr), prdata0, m_read(0, paddr));
            check32(tag_of(1, paddr), prdata1, m_read(1, paddr));
            if (rr0) pulses0++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge clk); #1;
        penable = 1;
        @(negedge clk); #1;
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic peek(input logic [11:0] a, output logic [31:0] d0, output logic [31:0] d1);
        @(negedge clk); #1;
        paddr = a; psel = 1; pwrite = 0; penable = 0;
        @(negedge clk);
        d0 = prdata0; d1 = prdata1;
        #1 psel = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d0, d1, e0;
        idle(4); #1 rst = 0;

        // R1: reset state and stopped counter
        peek(A_COUNT, d0, d1);
        check32("R1 count after reset", d0, 32'hFFFF_FFFF);
        peek(A_LOAD, d0, d1);
        check32("R1 reload after reset", d0, 32'hFFFF_FFFF);
        idle(5);
        peek(A_COUNT, d0, d1);
        check32("R1 counter stopped", d0, 32'hFFFF_FFFF);
        check32("R1 irq after reset", {31'b0, irq0}, 32'h0);

        // R2: reload write sets count without starting
        apb_wr(A_LOAD, 32'd20);
        idle(3);
        peek(A_COUNT, d0, d1);
        check32("R2 count follows reload, not running", d0, 32'd20);

        // R5: undefined control bits discarded
        apb_wr(A_CTRL, 32'hFFFF_FFF1);
        peek(A_CTRL, d0, d1);
        check32("R5 ctrl readback", d0, 32'h1);

        // R6/R9: expiry raises the interrupt
        paddr = A_COUNT;
        idle(30);
        check32("R6 irq after first expiry", {31'b0, irq0}, 32'h1);

        // R11: sticky variant ignores ctrl once enabled
        apb_wr(A_CTRL, 32'h3);
        peek(A_CTRL, d0, d1);
        check32("R5 ctrl rewrite plain", d0, 32'h3);
        check32("R11 sticky ctrl unchanged", d1, 32'h1);

        // R7: second expiry with pending interrupt
        idle(50);
        check32("R7 reset request seen", {31'b0, pulses0 > 0}, 32'h1);
        peek(A_RSTST, d0, d1);
        check32("R7 rststat set", d0, 32'h1);
        check32("R7 no request without reset-enable", d1, 32'h0);

        // R8: clear
        apb_wr(A_CLEAR, 32'h0);
        check32("R8 irq cleared", {31'b0, irq0}, 32'h0);

        // R4: freeze and unchanged writes
        apb_wr(A_CTRL, 32'h2);
        peek(A_COUNT, d0, d1);
        e0 = d0;
        idle(4);
        apb_wr(A_CTRL, 32'h2);
        peek(A_COUNT, d0, d1);
        check32("R4 count frozen", d0, e0);

        // R2/R3: reload while stopped, then start
        apb_wr(A_LOAD, 32'd5);
        peek(A_COUNT, d0, d1);
        check32("R2 count set while stopped", d0, 32'd5);
        apb_wr(A_CTRL, 32'h3);
        idle(12);

        // R10: lock
        apb_wr(A_LOCK, 32'h0);
        peek(A_LOCK, d0, d1);
        check32("R10 lock reads 1", d0, 32'h1);
        apb_wr(A_LOAD, 32'd77);
        peek(A_LOAD, d0, d1);
        check32("R10 reload write ignored when locked", d0, 32'd5);
        apb_wr(A_CTRL, 32'h0);
        peek(A_CTRL, d0, d1);
        check32("R10 ctrl write ignored when locked", d0, 32'h3);
        apb_wr(A_LOCK, KEY);
        peek(A_LOCK, d0, d1);
        check32("R10 unlock", d0, 32'h0);

        // unmapped and misaligned addresses
        apb_wr(12'h100, 32'd9);
        apb_wr(12'h001, 32'd9);
        peek(A_LOAD, d0, d1);
        check32("R2 unmapped write ignored", d0, 32'd5);

        // R6/R7: reload of zero expires every cycle
        apb_wr(A_LOAD, 32'd0);
        paddr = A_RAW;
        idle(10);
        apb_wr(A_CLEAR, 32'h1234);
        idle(6);

        // R1: reset mid-run, then R11 sticky writable again
        #1 rst = 1; idle(3); #1 rst = 0;
        peek(A_CTRL, d0, d1);
        check32("R1 ctrl after second reset", d1, 32'h0);
        check32("R1 rst_req after reset", {31'b0, rr0}, 32'h0);
        apb_wr(A_CTRL, 32'h1);
        peek(A_CTRL, d0, d1);
        check32("R11 sticky accepts first enable", d1, 32'h1);
        apb_wr(A_CTRL, 32'h0);
        peek(A_CTRL, d0, d1);
        check32("R11 sticky rejects disable", d1, 32'h1);
        check32("R11 plain accepts disable", d0, 32'h0);
        idle(5);

        finish_run();
    end

endmodule